// File: doc/BRIEF.md
# Linked Interrupt Log Writer

This block keeps a chronological record of standard interrupt events in system memory. Each accepted event carries a status word that gives the interrupt type and a reference pointer. In bus-controller operation the reference points at the command block. In remote-terminal operation it points at the subaddress or mode-code descriptor. The block does not need to know which mode is active. For every event it writes a three-word record: the status word, then the reference pointer, then a link word that the host has already placed there. The block reads that link to learn where the following record starts.

The records form a chain through the link words, so a log can be any length and can jump between scattered regions of memory. The host writes the list pointer register to choose the address of the first record. After each record the block loads that register with the link value it read. Events that arrive while a record is being written wait in a four-entry queue. When the queue is full, further events are dropped and a sticky flag is raised. All memory traffic goes through a single-port request/acknowledge master, and any number of stall cycles is tolerated.

Top module: `intlog_writer`

## Requirements
- R1: After synchronous reset, `list_ptr` is 0 and `busy`, `overflow` and `mem_req` are 0.
- R2: For each logged event, the status word is written to address `list_ptr` (the record base).
- R3: For each logged event, the reference pointer, zero-extended to the word width, is written to address base+1.
- R4: The link word at base+2 is only read (`mem_we`=0) and is never written.
- R5: Each record makes exactly three accesses in this order: write base, write base+1, read base+2. An access completes only in a cycle with `mem_req` and `mem_ack` both high. While it waits, `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` stay stable.
- R6: When the link read completes, `list_ptr` takes the low address bits of the word that was read.
- R7: A host write to `list_ptr` while idle sets the base address of the next record.
- R8: A host write to `list_ptr` during a record leaves that record's base unchanged. When the record completes, `list_ptr` keeps the host value and does not take the link.
- R9: `busy` is 1 from the cycle after an event is taken from the queue until the cycle after its link read completes, and it falls only then.
- R10: Up to four events that arrive while a record is in progress are queued and logged later in arrival order.
- R11: An event that arrives while the queue is full and nothing leaves the queue in that cycle is dropped. `overflow` then becomes 1 and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | One-cycle pulse per enabled standard interrupt event |
| evt_status | input | 16 | Interrupt status word for the event |
| evt_ref | input | 16 | Command block or descriptor pointer for the event |
| host_ptr_we | input | 1 | Host write strobe for the list pointer register |
| host_ptr_wdata | input | 16 | Host value for the list pointer register |
| list_ptr | output | 16 | Current list pointer register |
| busy | output | 1 | A record is being written |
| overflow | output | 1 | Sticky queue overflow flag |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_ack | input | 1 | Memory access complete |
| mem_rdata | input | 16 | Memory read data, valid with `mem_ack` on a read |

## Verification
Two pairs of functions can land in the same cycle. In the first, a host pointer write arrives while a record is open and competes with the link load into the register. The bench issues the write a few cycles into a record that is slowed by memory stalls. It then checks both the addresses of the current record and the final register value. In the second, new events arrive while the queue is full and the sequencer is not popping. A burst of seven back-to-back events against a slow memory gives five logged records along a prepared chain, an untouched sixth slot and a raised overflow flag.

// File: rtl/intlog_pkg.sv
package intlog_pkg;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 16;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef struct packed {
        word_t status;
        addr_t ref_ptr;
    } evt_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PUT_STATUS,
        ST_PUT_REF,
        ST_GET_LINK
    } seq_state_e;

    function automatic word_t ref_to_word(addr_t a);
        return word_t'(a);
    endfunction

    function automatic addr_t link_to_addr(word_t w);
        return w[ADDR_W-1:0];
    endfunction
endpackage

// File: rtl/intlog_queue.sv
module intlog_queue
    import intlog_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  evt_t push_data,
    input  logic pop,
    output evt_t pop_data,
    output logic not_empty,
    output logic overflow
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    evt_t             slots [DEPTH];
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rd_idx;
    logic [CNT_W-1:0] count;
    logic             full;
    logic             accept;
    logic             take;

    assign full      = (count == CNT_W'(DEPTH));
    assign not_empty = (count != '0);
    assign take      = pop && not_empty;
    assign accept    = push && (!full || take);
    assign pop_data  = slots[rd_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_idx   <= '0;
            rd_idx   <= '0;
            count    <= '0;
            overflow <= 1'b0;
        end else begin
            if (accept) begin
                slots[wr_idx] <= push_data;
                wr_idx <= (wr_idx == IDX_W'(DEPTH - 1)) ? '0 : wr_idx + 1'b1;
            end
            if (take) begin
                rd_idx <= (rd_idx == IDX_W'(DEPTH - 1)) ? '0 : rd_idx + 1'b1;
            end
            case ({accept, take})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            if (push && !accept) begin
                overflow <= 1'b1;
            end
        end
    end

    assert_pop_nonempty_R10: assert property (@(posedge clk) disable iff (rst)
        pop |-> not_empty);
    assert_count_bound_R10: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));
    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> overflow);
    assert_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);
endmodule

// File: rtl/intlog_seq.sv
module intlog_seq
    import intlog_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  q_valid,
    input  evt_t  q_data,
    output logic  q_pop,
    input  logic  host_we,
    input  addr_t host_wdata,
    output addr_t list_ptr,
    output logic  busy,
    output logic  mem_req,
    output logic  mem_we,
    output addr_t mem_addr,
    output word_t mem_wdata,
    input  logic  mem_ack,
    input  word_t mem_rdata
);
    seq_state_e state;
    evt_t       cur;
    addr_t      base;
    logic       host_pend;
    logic       done;

    assign q_pop = (state == ST_IDLE) && q_valid;
    assign busy  = (state != ST_IDLE);
    assign done  = mem_req && mem_ack;

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = base;
        mem_wdata = '0;
        case (state)
            ST_PUT_STATUS: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = cur.status;
            end
            ST_PUT_REF: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = base + addr_t'(1);
                mem_wdata = ref_to_word(cur.ref_ptr);
            end
            ST_GET_LINK: begin
                mem_req  = 1'b1;
                mem_addr = base + addr_t'(2);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cur       <= '0;
            base      <= '0;
            list_ptr  <= '0;
            host_pend <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (q_valid) begin
                        cur   <= q_data;
                        base  <= host_we ? host_wdata : list_ptr;
                        state <= ST_PUT_STATUS;
                    end
                end
                ST_PUT_STATUS: if (done) state <= ST_PUT_REF;
                ST_PUT_REF:    if (done) state <= ST_GET_LINK;
                ST_GET_LINK:   if (done) state <= ST_IDLE;
                default:       state <= ST_IDLE;
            endcase

            if (host_we) begin
                list_ptr <= host_wdata;
            end else if (state == ST_GET_LINK && done && !host_pend) begin
                list_ptr <= link_to_addr(mem_rdata);
            end

            if (state == ST_GET_LINK && done) begin
                host_pend <= 1'b0;
            end else if (host_we && state != ST_IDLE) begin
                host_pend <= 1'b1;
            end
        end
    end

    assert_req_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata)));
    assert_link_load_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack && !mem_we && !host_we && !host_pend)
        |=> (list_ptr == $past(mem_rdata[ADDR_W-1:0])));
    assert_host_wins_R8: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack && !mem_we && host_pend && !host_we) |=> $stable(list_ptr));
endmodule

// File: rtl/intlog_writer.sv
module intlog_writer
    import intlog_pkg::*;
#(
    parameter int QUEUE_DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        evt_valid,
    input  logic [15:0] evt_status,
    input  logic [15:0] evt_ref,
    input  logic        host_ptr_we,
    input  logic [15:0] host_ptr_wdata,
    output logic [15:0] list_ptr,
    output logic        busy,
    output logic        overflow,
    output logic        mem_req,
    output logic        mem_we,
    output logic [15:0] mem_addr,
    output logic [15:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [15:0] mem_rdata
);
    evt_t in_evt;
    evt_t head_evt;
    logic head_valid;
    logic head_pop;

    assign in_evt.status  = evt_status;
    assign in_evt.ref_ptr = evt_ref;

    intlog_queue #(.DEPTH(QUEUE_DEPTH)) u_queue (
        .clk       (clk),
        .rst       (rst),
        .push      (evt_valid),
        .push_data (in_evt),
        .pop       (head_pop),
        .pop_data  (head_evt),
        .not_empty (head_valid),
        .overflow  (overflow)
    );

    intlog_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .q_valid    (head_valid),
        .q_data     (head_evt),
        .q_pop      (head_pop),
        .host_we    (host_ptr_we),
        .host_wdata (host_ptr_wdata),
        .list_ptr   (list_ptr),
        .busy       (busy),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata)
    );

    assert_busy_end_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(mem_req && mem_ack && !mem_we));
endmodule

// File: tb/intlog_writer_tb.sv
module intlog_writer_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        evt_valid = 1'b0;
    logic [15:0] evt_status = '0;
    logic [15:0] evt_ref = '0;
    logic        host_ptr_we = 1'b0;
    logic [15:0] host_ptr_wdata = '0;
    logic [15:0] list_ptr;
    logic        busy;
    logic        overflow;
    logic        mem_req;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = '0;

    int errors = 0;
    int checks = 0;

    logic [15:0] tmem [256];
    int          lat = 0;
    int          wait_cnt = 0;
    logic        tb_we = 1'b0;
    logic [7:0]  tb_addr = '0;
    logic [15:0] tb_data = '0;

    logic [15:0] acc_addr [64];
    logic        acc_we   [64];
    int          acc_total = 0;
    int          hold_viol = 0;
    logic        prev_pend = 1'b0;
    logic [15:0] prev_addr = '0;
    logic [15:0] prev_wdata = '0;
    logic        prev_we = 1'b0;

    // {status, reference pointer, link}
    localparam logic [47:0] VEC [5] = '{
        48'h0001_1234_0020,
        48'h8002_00FF_0080,
        48'h0004_ABCD_0013,
        48'hFFFF_0000_00F0,
        48'h0010_5555_0040
    };

    intlog_writer u_dut (
        .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_status(evt_status),
        .evt_ref(evt_ref), .host_ptr_we(host_ptr_we), .host_ptr_wdata(host_ptr_wdata),
        .list_ptr(list_ptr), .busy(busy), .overflow(overflow), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        mem_ack <= 1'b0;
        if (tb_we) tmem[tb_addr] <= tb_data;
        if (rst) begin
            wait_cnt <= 0;
        end else if (mem_req && !mem_ack) begin
            if (wait_cnt >= lat) begin
                mem_ack  <= 1'b1;
                wait_cnt <= 0;
                if (mem_we) tmem[mem_addr[7:0]] <= mem_wdata;
                else        mem_rdata <= tmem[mem_addr[7:0]];
            end else begin
                wait_cnt <= wait_cnt + 1;
            end
        end
    end

    always @(posedge clk) begin
        if (!rst && prev_pend &&
            (!mem_req || mem_addr !== prev_addr || mem_we !== prev_we || mem_wdata !== prev_wdata))
            hold_viol <= hold_viol + 1;
        prev_pend  <= mem_req && !mem_ack && !rst;
        prev_addr  <= mem_addr;
        prev_we    <= mem_we;
        prev_wdata <= mem_wdata;
        if (!rst && mem_req && mem_ack) begin
            acc_addr[acc_total % 64] <= mem_addr;
            acc_we[acc_total % 64]   <= mem_we;
            acc_total <= acc_total + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic poke(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        tb_we = 1'b1; tb_addr = a; tb_data = d;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    task automatic send_event(input logic [15:0] s, input logic [15:0] r);
        @(negedge clk);
        evt_valid = 1'b1; evt_status = s; evt_ref = r;
        @(negedge clk);
        evt_valid = 1'b0;
    endtask

    task automatic host_write(input logic [15:0] v);
        @(negedge clk);
        host_ptr_we = 1'b1; host_ptr_wdata = v;
        @(negedge clk);
        host_ptr_we = 1'b0;
    endtask

    task automatic wait_idle();
        int quiet = 0;
        while (quiet < 4) begin
            @(negedge clk);
            if (busy) quiet = 0;
            else quiet++;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] p;
        int          st;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 list_ptr", 32'(list_ptr), 32'h0);
        chk("R1 busy", 32'(busy), 32'h0);
        chk("R1 overflow", 32'(overflow), 32'h0);
        chk("R1 mem_req", 32'(mem_req), 32'h0);

        // R7 host sets start of list
        host_write(16'h0010);
        @(negedge clk);
        chk("R7 list_ptr after host write", 32'(list_ptr), 32'h0010);
        p = 16'h0010;

        for (int i = 0; i < 5; i++) begin
            lat = i % 3;
            poke(p[7:0], 16'hDEAD);
            poke(p[7:0] + 8'd1, 16'hDEAD);
            poke(p[7:0] + 8'd2, VEC[i][15:0]);
            st = acc_total;
            send_event(VEC[i][47:32], VEC[i][31:16]);
            @(negedge clk);
            chk("R9 busy during record", 32'(busy), 32'h1);
            wait_idle();
            chk("R2 status word", 32'(tmem[p[7:0]]), 32'(VEC[i][47:32]));
            chk("R3 reference word", 32'(tmem[p[7:0] + 8'd1]), 32'(VEC[i][31:16]));
            chk("R5 access count", 32'(acc_total - st), 32'd3);
            chk("R5 first access", {15'd0, acc_we[st % 64], acc_addr[st % 64]}, {15'd0, 1'b1, p});
            chk("R5 second access", {15'd0, acc_we[(st + 1) % 64], acc_addr[(st + 1) % 64]},
                {15'd0, 1'b1, p + 16'd1});
            chk("R4 link read only", {15'd0, acc_we[(st + 2) % 64], acc_addr[(st + 2) % 64]},
                {15'd0, 1'b0, p + 16'd2});
            chk("R4 link unchanged", 32'(tmem[p[7:0] + 8'd2]), 32'(VEC[i][15:0]));
            chk("R6 pointer follows link", 32'(list_ptr), 32'(VEC[i][15:0]));
            chk("R9 busy low after record", 32'(busy), 32'h0);
            p = VEC[i][15:0];
        end

        // R8 host write during a record
        lat = 5;
        poke(8'h42, 16'h0060);
        poke(8'hA2, 16'h00B0);
        st = acc_total;
        send_event(16'h0A0A, 16'h0B0B);
        repeat (3) @(negedge clk);
        host_write(16'h00A0);
        wait_idle();
        chk("R8 current base kept", 32'(acc_addr[st % 64]), 32'h0040);
        chk("R8 status at old base", 32'(tmem[8'h40]), 32'h0A0A);
        chk("R8 host value wins", 32'(list_ptr), 32'h00A0);
        send_event(16'h0C0C, 16'h0D0D);
        wait_idle();
        chk("R8 next record at host value", 32'(tmem[8'hA0]), 32'h0C0C);
        chk("R6 pointer after next record", 32'(list_ptr), 32'h00B0);

        // R10 / R11 burst against a slow memory
        lat = 8;
        poke(8'hB2, 16'h00B8);
        poke(8'hBA, 16'h00C0);
        poke(8'hC2, 16'h00C8);
        poke(8'hCA, 16'h00D0);
        poke(8'hD2, 16'h00D8);
        poke(8'hD8, 16'hDEAD);
        poke(8'hDA, 16'h00E0);
        for (int k = 0; k < 7; k++) begin
            @(negedge clk);
            evt_valid = 1'b1; evt_status = 16'h0100 + 16'(k); evt_ref = 16'h0700 + 16'(k);
        end
        @(negedge clk);
        evt_valid = 1'b0;
        wait_idle();
        for (int k = 0; k < 5; k++) begin
            chk("R10 queued status in order", 32'(tmem[8'hB0 + 8'(8 * k)]), 32'h0100 + 32'(k));
            chk("R10 queued reference in order", 32'(tmem[8'hB1 + 8'(8 * k)]), 32'h0700 + 32'(k));
        end
        chk("R11 dropped event not logged", 32'(tmem[8'hD8]), 32'hDEAD);
        chk("R11 overflow set", 32'(overflow), 32'h1);
        chk("R6 pointer after burst", 32'(list_ptr), 32'h00D8);
        repeat (10) @(negedge clk);
        chk("R11 overflow sticky", 32'(overflow), 32'h1);
        chk("R5 no stall violations", 32'(hold_viol), 32'h0);
        do_reset();
        @(negedge clk);
        chk("R11 overflow cleared by reset", 32'(overflow), 32'h0);
        chk("R1 list_ptr after reset", 32'(list_ptr), 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule